// File: doc/BRIEF.md
# Zero-Block Compressed Memory Controller

This controller sits in front of a memory that keeps only blocks holding at least one non-zero bit. It translates an uncompressed (page, block) address into a location in a compressed space, or reports that the block is all zeros so that no data access is needed. Every uncompressed page owns a descriptor with a single compressed-space selector for the whole page. For each block in the page, the descriptor also holds a zero flag and a way index. Each compressed space is organised as a set-associative store. The set is the block's offset within its page, and the way index picks a slot within that set. A per-space occupancy map holds one bit per slot.

Reads return a zero indication, or a physical compressed address of the form {space, block offset, way}, one cycle after the request. A write reports whether the block's new content is all zeros. The controller changes its bookkeeping only when the block's zero status flips. A block that becomes zero gives its slot back to the map. A block that stops being zero takes the lowest free way in its set. If that set is full, the controller raises a fault so that an outside engine can move the page to another space. An initialisation port points a page at a chosen space and marks all of its blocks as zero.

Top module: `zblk_mem_ctrl`

## Requirements
- R1: After reset, every block of every page reads as zero. Page p uses space p mod SPACES. Every slot of every space is free.
- R2: A read of a zero block raises rd_done exactly one cycle after rd_valid, with rd_zero=1 and rd_addr=0.
- R3: A read of a non-zero block returns rd_zero=0 and rd_addr = {space[1:0], block[3:0], way[1:0]}, with the space in the most significant bits and the way in the least.
- R4: A write that keeps the block's status (zero over zero, or non-zero over non-zero) leaves the descriptor and the occupancy map unchanged. wr_addr then returns the block's existing address, or 0 for a zero block.
- R5: Writing zero over a non-zero block makes later reads return zero and frees its slot, so the next allocation in that set can reuse the slot.
- R6: Writing non-zero over a zero block allocates the lowest-numbered free way in set (page space, block offset). The resulting address is reported on wr_addr one cycle later, and later reads return that same address.
- R7: When a write needs a slot and the set is full, move_fault and wr_done rise one cycle later with wr_addr=0, and the block still reads as zero.
- R8: init_valid sets the page's space selector to init_space and marks all blocks of the page as zero. Later allocations for that page use the new space.
- R9: A write presented in the same cycle as init_valid is dropped: wr_done stays low and the descriptor is not changed by the write.
- R10: A read in the same cycle as a write to the same block returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_valid | input | 1 | Re-point a page and clear it to all-zero blocks |
| init_page | input | 3 | Page to initialise |
| init_space | input | 2 | New compressed-space selector |
| rd_valid | input | 1 | Read request |
| rd_page | input | 3 | Read page |
| rd_blk | input | 4 | Read block offset |
| rd_done | output | 1 | Read result valid |
| rd_zero | output | 1 | Block is all zeros |
| rd_addr | output | 8 | Compressed address {space, block, way} |
| wr_valid | input | 1 | Write request |
| wr_page | input | 3 | Write page |
| wr_blk | input | 4 | Write block offset |
| wr_is_null | input | 1 | New block content is all zeros |
| wr_done | output | 1 | Write result valid |
| wr_addr | output | 8 | Slot holding the written block, 0 if the block is zero or on fault |
| move_fault | output | 1 | No free slot, so the page must move |

## Verification
Writes are tried in all four combinations of old and new zero status. This separates the two no-op cases from allocation and release. Several pages are pointed at one space and fill a single set. This shows lowest-way selection, reuse of a released way, and the fault when the fifth claimant arrives. A neighbouring set in the same space is then shown to be unaffected. Same-cycle collisions are also tested: an init together with a write, and a read together with a write. These show that init takes priority and that a read sees the state from before the write.

// File: rtl/zbc_pkg.sv
// Shared types for the zero-block compressed memory controller.
package zbc_pkg;
    // Kind of bookkeeping a write triggers.
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_FREE  = 2'd1,
        ACT_ALLOC = 2'd2,
        ACT_FAULT = 2'd3
    } wr_act_e;
endpackage

// File: rtl/zbc_desc_table.sv
// Page descriptor table: per page, one space selector; per block, a zero
// flag and a way index. Two combinational lookup ports (read, write).
// Assumes PAGES, BLKS, WAYS, SPACES are powers of two and at least 2.
// Init and per-block updates are never requested in the same cycle.
module zbc_desc_table #(
    parameter int PAGES  = 8,
    parameter int BLKS   = 16,
    parameter int WAYS   = 4,
    parameter int SPACES = 4,
    localparam int PG_W = $clog2(PAGES),
    localparam int BK_W = $clog2(BLKS),
    localparam int WY_W = $clog2(WAYS),
    localparam int CS_W = $clog2(SPACES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] rd_page,
    input  logic [BK_W-1:0] rd_blk,
    output logic [CS_W-1:0] rd_cs,
    output logic            rd_null,
    output logic [WY_W-1:0] rd_way,
    input  logic [PG_W-1:0] wr_page,
    input  logic [BK_W-1:0] wr_blk,
    output logic [CS_W-1:0] wr_cs,
    output logic            wr_null,
    output logic [WY_W-1:0] wr_way,
    input  logic            init_en,
    input  logic [PG_W-1:0] init_page,
    input  logic [CS_W-1:0] init_cs,
    input  logic            mark_null_en,
    input  logic            mark_way_en,
    input  logic [WY_W-1:0] mark_way
);
    logic [CS_W-1:0] cs_q   [PAGES];
    logic [BLKS-1:0] null_q [PAGES];
    logic [WY_W-1:0] way_q  [PAGES][BLKS];

    // Lookup for the read port.
    always_comb begin
        rd_cs   = cs_q[rd_page];
        rd_null = null_q[rd_page][rd_blk];
        rd_way  = way_q[rd_page][rd_blk];
    end

    // Lookup for the write port.
    always_comb begin
        wr_cs   = cs_q[wr_page];
        wr_null = null_q[wr_page][wr_blk];
        wr_way  = way_q[wr_page][wr_blk];
    end

    // Descriptor state: reset, page init, per-block status updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                cs_q[p]   <= CS_W'(p % SPACES);
                null_q[p] <= '1;
                for (int b = 0; b < BLKS; b++) way_q[p][b] <= '0;
            end
        end else if (init_en) begin
            cs_q[init_page]   <= init_cs;
            null_q[init_page] <= '1;
        end else begin
            if (mark_null_en) null_q[wr_page][wr_blk] <= 1'b1;
            if (mark_way_en) begin
                null_q[wr_page][wr_blk] <= 1'b0;
                way_q[wr_page][wr_blk]  <= mark_way;
            end
        end
    end

    // R8: after init every block of the page is zero.
    assert_init_clears_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_en |=> null_q[$past(init_page)] == '1);
    // R6: a recorded allocation leaves the block non-zero with that way.
    assert_alloc_records_way_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_way_en && !init_en) |=> (!null_q[$past(wr_page)][$past(wr_blk)]
            && way_q[$past(wr_page)][$past(wr_blk)] == $past(mark_way)));
endmodule

// File: rtl/zbc_free_map.sv
// Slot occupancy map: one bit per (space, set, way), 1 = free.
// Provides the lowest free way of a looked-up set and takes allocate and
// release requests. Assumes allocate and release never coincide.
module zbc_free_map #(
    parameter int BLKS   = 16,
    parameter int WAYS   = 4,
    parameter int SPACES = 4,
    localparam int BK_W = $clog2(BLKS),
    localparam int WY_W = $clog2(WAYS),
    localparam int CS_W = $clog2(SPACES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CS_W-1:0] look_cs,
    input  logic [BK_W-1:0] look_set,
    output logic            pick_ok,
    output logic [WY_W-1:0] pick_way,
    input  logic            alloc_en,
    input  logic [WY_W-1:0] alloc_way,
    input  logic            rel_en,
    input  logic [WY_W-1:0] rel_way
);
    logic [WAYS-1:0] free_q [SPACES][BLKS];
    logic [WAYS-1:0] set_free;

    // Lowest-numbered free way of the looked-up set.
    always_comb begin
        set_free = free_q[look_cs][look_set];
        pick_ok  = |set_free;
        pick_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (set_free[w]) pick_way = WY_W'(w);
        end
    end

    // Occupancy state: all free on reset, then allocate or release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SPACES; s++)
                for (int b = 0; b < BLKS; b++) free_q[s][b] <= '1;
        end else if (alloc_en) begin
            free_q[look_cs][look_set][alloc_way] <= 1'b0;
        end else if (rel_en) begin
            free_q[look_cs][look_set][rel_way] <= 1'b1;
        end
    end

    // R6: only a free slot may be claimed.
    assert_alloc_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_q[look_cs][look_set][alloc_way]);
    // R5: only an occupied slot may be released.
    assert_release_slot_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> !free_q[look_cs][look_set][rel_way]);
    // R5/R6: a slot is never both claimed and released in one cycle.
    assert_no_alloc_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_en && rel_en));
endmodule

// File: rtl/zblk_mem_ctrl.sv
// Zero-block compressed memory controller top.
// Translates (page, block) into a compressed address or a zero indication,
// and keeps descriptors and slot occupancy in step with block zero status.
// Assumes freeing the slots of a re-pointed page is done outside the block.
module zblk_mem_ctrl #(
    parameter int PAGES  = 8,
    parameter int BLKS   = 16,
    parameter int WAYS   = 4,
    parameter int SPACES = 4,
    localparam int PG_W = $clog2(PAGES),
    localparam int BK_W = $clog2(BLKS),
    localparam int WY_W = $clog2(WAYS),
    localparam int CS_W = $clog2(SPACES),
    localparam int CA_W = CS_W + BK_W + WY_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_valid,
    input  logic [PG_W-1:0] init_page,
    input  logic [CS_W-1:0] init_space,
    input  logic            rd_valid,
    input  logic [PG_W-1:0] rd_page,
    input  logic [BK_W-1:0] rd_blk,
    output logic            rd_done,
    output logic            rd_zero,
    output logic [CA_W-1:0] rd_addr,
    input  logic            wr_valid,
    input  logic [PG_W-1:0] wr_page,
    input  logic [BK_W-1:0] wr_blk,
    input  logic            wr_is_null,
    output logic            wr_done,
    output logic [CA_W-1:0] wr_addr,
    output logic            move_fault
);
    import zbc_pkg::*;

    logic [CS_W-1:0] d_rd_cs, d_wr_cs;
    logic            d_rd_null, d_wr_null;
    logic [WY_W-1:0] d_rd_way, d_wr_way;
    logic            pick_ok;
    logic [WY_W-1:0] pick_way;
    logic            wr_take;
    wr_act_e         act;
    logic [CA_W-1:0] wr_addr_nxt;

    zbc_desc_table #(
        .PAGES(PAGES), .BLKS(BLKS), .WAYS(WAYS), .SPACES(SPACES)
    ) u_desc (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_page     (rd_page),
        .rd_blk      (rd_blk),
        .rd_cs       (d_rd_cs),
        .rd_null     (d_rd_null),
        .rd_way      (d_rd_way),
        .wr_page     (wr_page),
        .wr_blk      (wr_blk),
        .wr_cs       (d_wr_cs),
        .wr_null     (d_wr_null),
        .wr_way      (d_wr_way),
        .init_en     (init_valid),
        .init_page   (init_page),
        .init_cs     (init_space),
        .mark_null_en(act == ACT_FREE),
        .mark_way_en (act == ACT_ALLOC),
        .mark_way    (pick_way)
    );

    zbc_free_map #(
        .BLKS(BLKS), .WAYS(WAYS), .SPACES(SPACES)
    ) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_cs  (d_wr_cs),
        .look_set (wr_blk),
        .pick_ok  (pick_ok),
        .pick_way (pick_way),
        .alloc_en (act == ACT_ALLOC),
        .alloc_way(pick_way),
        .rel_en   (act == ACT_FREE),
        .rel_way  (d_wr_way)
    );

    // Classify the write by old and new zero status; init wins over write.
    always_comb begin
        wr_take     = wr_valid && !init_valid;
        act         = ACT_KEEP;
        wr_addr_nxt = '0;
        if (wr_take) begin
            if (wr_is_null && !d_wr_null) begin
                act = ACT_FREE;
            end else if (!wr_is_null && d_wr_null) begin
                if (pick_ok) begin
                    act         = ACT_ALLOC;
                    wr_addr_nxt = {d_wr_cs, wr_blk, pick_way};
                end else begin
                    act = ACT_FAULT;
                end
            end else if (!wr_is_null) begin
                wr_addr_nxt = {d_wr_cs, wr_blk, d_wr_way};
            end
        end
    end

    // Registered read response from the pre-edge descriptor state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_done <= 1'b0;
            rd_zero <= 1'b0;
            rd_addr <= '0;
        end else begin
            rd_done <= rd_valid;
            rd_zero <= rd_valid && d_rd_null;
            rd_addr <= (rd_valid && !d_rd_null) ? {d_rd_cs, rd_blk, d_rd_way} : '0;
        end
    end

    // Registered write response and fault indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_done    <= 1'b0;
            wr_addr    <= '0;
            move_fault <= 1'b0;
        end else begin
            wr_done    <= wr_take;
            wr_addr    <= wr_addr_nxt;
            move_fault <= (act == ACT_FAULT);
        end
    end

    // R2: every read answers exactly one cycle later.
    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_done);
    // R2: a zero answer carries no address.
    assert_zero_no_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_zero) |-> rd_addr == '0);
    // R7: a fault is a write response without a slot.
    assert_fault_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        move_fault |-> (wr_done && wr_addr == '0));
    // R9: a write colliding with init yields no response.
    assert_init_drops_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> !wr_done);
endmodule

// File: tb/zblk_mem_ctrl_bench.sv
`timescale 1ns/1ps
module zblk_mem_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_valid = 1'b0;
    logic [2:0] init_page = '0;
    logic [1:0] init_space = '0;
    logic       rd_valid = 1'b0;
    logic [2:0] rd_page = '0;
    logic [3:0] rd_blk = '0;
    logic       rd_done, rd_zero;
    logic [7:0] rd_addr;
    logic       wr_valid = 1'b0;
    logic [2:0] wr_page = '0;
    logic [3:0] wr_blk = '0;
    logic       wr_is_null = 1'b0;
    logic       wr_done, move_fault;
    logic [7:0] wr_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    zblk_mem_ctrl u_zblk_mem_ctrl (
        .clk(clk), .rst_n(rst_n),
        .init_valid(init_valid), .init_page(init_page), .init_space(init_space),
        .rd_valid(rd_valid), .rd_page(rd_page), .rd_blk(rd_blk),
        .rd_done(rd_done), .rd_zero(rd_zero), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_page(wr_page), .wr_blk(wr_blk),
        .wr_is_null(wr_is_null), .wr_done(wr_done), .wr_addr(wr_addr),
        .move_fault(move_fault)
    );

    // Vector: {op[1:0] 0=write 1=read 2=init, page[2:0], blk/space[3:0],
    //          is_null, exp_fault, exp_zero, exp_addr[7:0]}, tag number last.
    localparam int NV = 17;
    localparam logic [19:0] VEC [NV] = '{
        {2'd1, 3'd1, 4'd3,  1'b0, 1'b0, 1'b1, 8'h00}, // R1 R2 fresh block zero
        {2'd0, 3'd1, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4C}, // R6 space1 set3 way0
        {2'd1, 3'd1, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4C}, // R3 read back
        {2'd0, 3'd5, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4D}, // R6 next lowest way1
        {2'd0, 3'd1, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4C}, // R4 non-zero over non-zero
        {2'd0, 3'd2, 4'd0,  1'b1, 1'b0, 1'b0, 8'h00}, // R4 zero over zero
        {2'd0, 3'd1, 4'd3,  1'b1, 1'b0, 1'b0, 8'h00}, // R5 release way0
        {2'd1, 3'd1, 4'd3,  1'b0, 1'b0, 1'b1, 8'h00}, // R5 reads zero
        {2'd0, 3'd1, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4C}, // R5 way0 reused
        {2'd2, 3'd0, 4'd1,  1'b0, 1'b0, 1'b0, 8'h00}, // R8 page0 -> space1
        {2'd0, 3'd0, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4E}, // R8 R6 way2 in space1
        {2'd2, 3'd4, 4'd1,  1'b0, 1'b0, 1'b0, 8'h00}, // R8 page4 -> space1
        {2'd0, 3'd4, 4'd3,  1'b0, 1'b0, 1'b0, 8'h4F}, // R6 way3 fills set
        {2'd2, 3'd2, 4'd1,  1'b0, 1'b0, 1'b0, 8'h00}, // R8 page2 -> space1
        {2'd0, 3'd2, 4'd3,  1'b0, 1'b1, 1'b0, 8'h00}, // R7 set full
        {2'd1, 3'd2, 4'd3,  1'b0, 1'b0, 1'b1, 8'h00}, // R7 still zero
        {2'd0, 3'd2, 4'd7,  1'b0, 1'b0, 1'b0, 8'h5C}  // R7 other set fine
    };
    localparam int TAG [NV] = '{1, 6, 3, 6, 4, 4, 5, 5, 5, 8, 8, 8, 6, 8, 7, 7, 7};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        init_valid = 1'b0; rd_valid = 1'b0; wr_valid = 1'b0;
    endtask

    task automatic run_vec(input logic [19:0] v, input int tag);
        string req;
        req = $sformatf("R%0d", tag);
        @(negedge clk);
        case (v[19:18])
            2'd0: begin wr_valid = 1'b1; wr_page = v[17:15]; wr_blk = v[14:11]; wr_is_null = v[10]; end
            2'd1: begin rd_valid = 1'b1; rd_page = v[17:15]; rd_blk = v[14:11]; end
            default: begin init_valid = 1'b1; init_page = v[17:15]; init_space = v[12:11]; end
        endcase
        @(negedge clk);
        idle();
        if (v[19:18] == 2'd0)
            check(req, {6'd0, wr_done, move_fault, wr_addr}, {6'd0, 1'b1, v[9], v[7:0]});
        else if (v[19:18] == 2'd1)
            check(req, {6'd0, rd_done, rd_zero, rd_addr}, {6'd0, 1'b1, v[8], v[7:0]});
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {13'd0, rd_done, wr_done, move_fault}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_vec(VEC[i], TAG[i]);

        // R10: read and write of the same block in one cycle; read sees old state.
        @(negedge clk);
        wr_valid = 1'b1; wr_page = 3'd1; wr_blk = 4'd3; wr_is_null = 1'b1;
        rd_valid = 1'b1; rd_page = 3'd1; rd_blk = 4'd3;
        @(negedge clk);
        idle();
        check("R10 read before write", {6'd0, rd_done, rd_zero, rd_addr}, {6'd0, 2'b10, 8'h4C});
        run_vec({2'd1, 3'd1, 4'd3, 1'b0, 1'b0, 1'b1, 8'h00}, 10);

        // R9: init and write together; write is dropped.
        @(negedge clk);
        init_valid = 1'b1; init_page = 3'd3; init_space = 2'd3;
        wr_valid = 1'b1; wr_page = 3'd3; wr_blk = 4'd0; wr_is_null = 1'b0;
        @(negedge clk);
        idle();
        check("R9 no write response", {15'd0, wr_done}, 16'd0);
        run_vec({2'd1, 3'd3, 4'd0, 1'b0, 1'b0, 1'b1, 8'h00}, 9);
        run_vec({2'd0, 3'd3, 4'd0, 1'b0, 1'b0, 1'b0, 8'hC0}, 9);

        // R1: second reset restores selectors and empties every set.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_vec({2'd1, 3'd0, 4'd3, 1'b0, 1'b0, 1'b1, 8'h00}, 1);
        run_vec({2'd0, 3'd0, 4'd3, 1'b0, 1'b0, 1'b0, 8'h0C}, 1);
        run_vec({2'd0, 3'd5, 4'd3, 1'b0, 1'b0, 1'b0, 8'h4C}, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule